// File: doc/BRIEF.md
# Dual-Line Serial Flash OTP and Write-Enable Target

This block is the target side of a serial flash port that runs in dual-line mode. A host drives chip select (active low) and a serial clock. The two data lines move two bits per serial clock in every phase that carries bits. The block answers two commands. Write Enable sets a sticky write-enable flag. The one-time-programmable read command takes a 24-bit address, waits through a fixed number of dummy clocks, and then streams bytes from a 64-byte array on both lines until the host deselects.

The serial pins are sampled by a fast system clock. Chip select, serial clock and the input data lines pass through a synchronizer, and the serial clock edges are found by comparing two successive samples. Every output is a register. The OTP array has a synchronous write port that loads its contents, and it is read synchronously so that it can map onto block RAM. Each data line has its own output-enable pin, and both enables are driven together.

Serial timing: the target samples on the rising serial clock edge and changes its outputs on the falling edge. The serial clock idles low. It must run several times slower than the system clock.

Top module: `flash_dual_otp_target`

## Requirements
- R1: While reset is held and after it is released, dq_oe is 00, dq_out is 00 and wel is 0.
- R2: Opcode 0x06 (Write Enable) is sent in 4 clocks, two bits per clock, most significant pair first. The higher bit of each pair is on line 1 and the lower bit on line 0. If chip select then rises after exactly those 4 clocks, wel becomes 1.
- R3: A 0x06 opcode cut short by deselect after 3 clocks, or followed by a fifth clock before deselect, leaves wel unchanged.
- R4: After any opcode other than 0x06 and 0x4B, both lines stay tri-stated for every further clock until deselect, and wel is unchanged.
- R5: Opcode 0x4B is followed by a 24-bit address sent most significant pair first over 12 clocks. Only the low 6 address bits select the starting byte, and the upper 18 bits have no effect.
- R6: Eight dummy clocks follow the address, each taking a full clock. The lines stay tri-stated through them. Output enable and the first data pair appear on the falling edge after clock 23, counting the first opcode clock as clock 0.
- R7: Each data byte is sent over 4 clocks, most significant pair first, with bit 7 on line 1 and bit 6 on line 0 in the first pair. The outputs change only on falling serial clock edges.
- R8: Data continues byte after byte while clocks continue, with the address advancing by one and wrapping from 63 to 0.
- R9: Raising chip select at any point aborts the command. Within a few system clocks both lines are tri-stated, and the next command is decoded from its first clock.
- R10: A write on the preload port (otp_we, otp_waddr, otp_wdata) replaces the stored byte that a later read returns.
- R11: Once set, wel stays 1 through later commands until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sck | input | 1 | Serial clock, idles low |
| dq_in | input | 2 | Input value of the two data lines (bit 1 = line 1) |
| dq_out | output | 2 | Output value of the two data lines |
| dq_oe | output | 2 | Output enable for each line, 1 = drive |
| wel | output | 1 | Write-enable flag |
| otp_we | input | 1 | Preload write strobe |
| otp_waddr | input | 6 | Preload byte address |
| otp_wdata | input | 8 | Preload byte value |

## Verification
The hardest case to reach from the ports is the wrap of a continuous read from byte 63 back to byte 0, because the host must keep the clock running for more bytes than the array holds. The bench starts a read at byte 60 and runs it for 68 bytes, so the wrap point is crossed and the stream returns to byte 0. It also sweeps every starting byte, each time with different upper address bits that must have no effect. Write Enable is checked with deselect placed one clock early, exactly on time and one clock late.

// File: rtl/flash_dual_pkg.sv
package flash_dual_pkg;
  typedef enum logic [2:0] {
    ST_OFF,
    ST_OPC,
    ST_WEN_WAIT,
    ST_ADDR,
    ST_DUMMY,
    ST_DATA,
    ST_SKIP
  } fd_state_e;
endpackage

// File: rtl/fd_in_sync.sv
module fd_in_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) q <= RST_VAL;
        else     q <= d;
      end
    end else begin : g_chain
      logic [STAGES*W-1:0] chain;
      always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{RST_VAL}};
        else     chain <= {chain[(STAGES-1)*W-1:0], d};
      end
      assign q = chain[STAGES*W-1 -: W];
    end
  endgenerate
endmodule

// File: rtl/fd_otp_store.sv
module fd_otp_store #(
  parameter int AW = 6,
  parameter int DW = 8,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/fd_cmd_engine.sv
module fd_cmd_engine
  import flash_dual_pkg::*;
#(
  parameter int AW         = 6,
  parameter int DW         = 8,
  parameter int ADDR_CLKS  = 12,
  parameter int DUMMY_CLKS = 8,
  parameter logic [7:0] OPC_WEN  = 8'h06,
  parameter logic [7:0] OPC_ROTP = 8'h4B
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_s,
  input  logic          sck_rise,
  input  logic          sck_fall,
  input  logic [1:0]    dq_s,
  input  logic [DW-1:0] rdata,
  output logic [AW-1:0] raddr,
  output logic [1:0]    dq_out,
  output logic          oe,
  output logic          wel
);
  localparam int OPC_CLKS = 4;
  localparam int MAXC     = (ADDR_CLKS > DUMMY_CLKS) ? ADDR_CLKS : DUMMY_CLKS;
  localparam int CW       = $clog2(MAXC) + 1;
  localparam int GRPS     = DW / 2;
  localparam int GW       = (GRPS > 1) ? $clog2(GRPS) : 1;

  fd_state_e     state;
  logic [CW-1:0] cnt;
  logic [5:0]    op_sh;
  logic [AW-1:0] a_sh;
  logic [AW-1:0] ptr;
  logic [DW-1:0] obyte;
  logic [GW-1:0] grp;
  logic [7:0]    op_full;

  assign op_full = {op_sh, dq_s};
  assign raddr   = ptr;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_OFF;
      cnt    <= '0;
      op_sh  <= '0;
      a_sh   <= '0;
      ptr    <= '0;
      obyte  <= '0;
      grp    <= '0;
      dq_out <= '0;
      oe     <= 1'b0;
      wel    <= 1'b0;
    end else if (cs_s) begin
      if (state == ST_WEN_WAIT) wel <= 1'b1;
      state <= ST_OFF;
      cnt   <= '0;
      grp   <= '0;
      oe    <= 1'b0;
    end else begin
      case (state)
        ST_OFF: begin
          state <= ST_OPC;
          cnt   <= '0;
        end
        ST_OPC: if (sck_rise) begin
          op_sh <= {op_sh[3:0], dq_s};
          cnt   <= cnt + 1'b1;
          if (cnt == CW'(OPC_CLKS - 1)) begin
            cnt <= '0;
            if (op_full == OPC_WEN)       state <= ST_WEN_WAIT;
            else if (op_full == OPC_ROTP) state <= ST_ADDR;
            else                          state <= ST_SKIP;
          end
        end
        ST_WEN_WAIT: if (sck_rise) state <= ST_SKIP;
        ST_ADDR: if (sck_rise) begin
          a_sh <= {a_sh[AW-3:0], dq_s};
          cnt  <= cnt + 1'b1;
          if (cnt == CW'(ADDR_CLKS - 1)) begin
            ptr   <= {a_sh[AW-3:0], dq_s};
            cnt   <= '0;
            state <= ST_DUMMY;
          end
        end
        ST_DUMMY: if (sck_rise) begin
          cnt <= cnt + 1'b1;
          if (cnt == CW'(DUMMY_CLKS - 1)) begin
            cnt   <= '0;
            grp   <= '0;
            state <= ST_DATA;
          end
        end
        ST_DATA: if (sck_fall) begin
          oe  <= 1'b1;
          grp <= grp + 1'b1;
          if (grp == '0) begin
            dq_out <= rdata[DW-1:DW-2];
            obyte  <= {rdata[DW-3:0], 2'b00};
            ptr    <= ptr + 1'b1;
          end else begin
            dq_out <= obyte[DW-1:DW-2];
            obyte  <= {obyte[DW-3:0], 2'b00};
          end
        end
        ST_SKIP: ;
        default: state <= ST_OFF;
      endcase
    end
  end
endmodule

// File: rtl/flash_dual_otp_target.sv
module flash_dual_otp_target #(
  parameter int OTP_AW     = 6,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_CLKS  = 12,
  parameter int DUMMY_CLKS = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              spi_cs_n,
  input  logic              spi_sck,
  input  logic [1:0]        dq_in,
  output logic [1:0]        dq_out,
  output logic [1:0]        dq_oe,
  output logic              wel,
  input  logic              otp_we,
  input  logic [OTP_AW-1:0] otp_waddr,
  input  logic [7:0]        otp_wdata
);
  localparam int DW = 8;

  logic [3:0]        pins_s;
  logic              cs_s, sck_s, sck_q, sck_rise, sck_fall, oe;
  logic [1:0]        dq_s;
  logic [OTP_AW-1:0] raddr;
  logic [DW-1:0]     rdata;

  fd_in_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1000)) u_sync (
    .clk(clk), .rst(rst), .d({spi_cs_n, spi_sck, dq_in}), .q(pins_s)
  );

  assign cs_s  = pins_s[3];
  assign sck_s = pins_s[2];
  assign dq_s  = pins_s[1:0];

  always_ff @(posedge clk) begin
    if (rst) sck_q <= 1'b0;
    else     sck_q <= sck_s;
  end

  assign sck_rise = sck_s & ~sck_q;
  assign sck_fall = ~sck_s & sck_q;

  fd_otp_store #(.AW(OTP_AW), .DW(DW)) u_store (
    .clk(clk), .we(otp_we), .waddr(otp_waddr), .wdata(otp_wdata),
    .raddr(raddr), .rdata(rdata)
  );

  fd_cmd_engine #(
    .AW(OTP_AW), .DW(DW), .ADDR_CLKS(ADDR_CLKS), .DUMMY_CLKS(DUMMY_CLKS)
  ) u_eng (
    .clk(clk), .rst(rst), .cs_s(cs_s), .sck_rise(sck_rise), .sck_fall(sck_fall),
    .dq_s(dq_s), .rdata(rdata), .raddr(raddr), .dq_out(dq_out), .oe(oe), .wel(wel)
  );

  assign dq_oe = {oe, oe};
endmodule

// File: rtl/fd_checker.sv
module fd_checker (
  input logic       clk,
  input logic       rst,
  input logic       cs_s,
  input logic       sck_fall,
  input logic [1:0] dq_out,
  input logic [1:0] dq_oe,
  input logic       wel
);
  assert_tristate_deselect_R9: assert property (@(posedge clk) disable iff (rst)
    cs_s |=> (dq_oe == 2'b00));

  assert_out_on_fall_R7: assert property (@(posedge clk) disable iff (rst)
    !sck_fall |=> $stable(dq_out));

  assert_oe_on_fall_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(dq_oe[0]) |-> $past(sck_fall));

  assert_wel_sticky_R11: assert property (@(posedge clk) disable iff (rst)
    wel |=> wel);

  assert_wel_at_deselect_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(wel) |-> $past(cs_s));
endmodule

bind flash_dual_otp_target fd_checker u_chk (.*);

// File: tb/sim_flash_dual_otp_target.sv
module sim_flash_dual_otp_target;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 6;
  localparam int WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       spi_cs_n = 1'b1;
  logic       spi_sck = 1'b0;
  logic [1:0] dq_in = 2'b00;
  logic [1:0] dq_out, dq_oe;
  logic       wel;
  logic       otp_we = 1'b0;
  logic [5:0] otp_waddr = '0;
  logic [7:0] otp_wdata = '0;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_dual_otp_target u0 (
    .clk(clk), .rst(rst), .spi_cs_n(spi_cs_n), .spi_sck(spi_sck), .dq_in(dq_in),
    .dq_out(dq_out), .dq_oe(dq_oe), .wel(wel),
    .otp_we(otp_we), .otp_waddr(otp_waddr), .otp_wdata(otp_wdata)
  );

  function automatic logic [7:0] pat(input int i);
    return 8'((i * 37 + 11) & 255);
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clk_grp(input logic [1:0] g, output logic [1:0] so, output logic [1:0] soe);
    dq_in = g;
    repeat (HALF) @(negedge clk);
    so  = dq_out;
    soe = dq_oe;
    spi_sck = 1'b1;
    repeat (HALF) @(negedge clk);
    spi_sck = 1'b0;
  endtask

  task automatic select();
    spi_cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic deselect();
    repeat (HALF) @(negedge clk);
    spi_cs_n = 1'b1;
    repeat (10) @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] b, input int npairs);
    logic [1:0] so, soe;
    for (int i = 0; i < npairs; i++) clk_grp(b[7-2*i -: 2], so, soe);
  endtask

  task automatic rd_otp(input logic [23:0] addr, input int nbytes);
    logic [1:0] so, soe;
    logic [7:0] got;
    int start;
    start = int'(addr[5:0]);
    select();
    send_byte(8'h4B, 4);
    for (int i = 0; i < 12; i++) clk_grp(addr[23-2*i -: 2], so, soe);
    for (int i = 0; i < 8; i++) begin
      clk_grp(2'b00, so, soe);
      // R6: lines tri-stated up to and including clock 23
      check(soe == 2'b00, "R6 dummy oe", int'(soe), 0);
    end
    for (int b = 0; b < nbytes; b++) begin
      got = '0;
      for (int k = 0; k < 4; k++) begin
        clk_grp(2'b00, so, soe);
        got = {got[5:0], so};
        if (k == 0) check(soe == 2'b11, "R6 data oe", int'(soe), 3);
      end
      // R5 R7 R8: byte at (start + b) mod 64
      check(got == pat((start + b) % 64), "R7 R8 data byte", int'(got), int'(pat((start + b) % 64)));
    end
    deselect();
    check(dq_oe == 2'b00, "R9 oe after deselect", int'(dq_oe), 0);
  endtask

  initial begin
    logic [1:0] so, soe;
    logic [7:0] got;
    repeat (5) @(negedge clk);
    check(dq_oe == 2'b00 && dq_out == 2'b00 && wel == 1'b0, "R1 in reset",
          int'({dq_oe, dq_out, wel}), 0);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    check(dq_oe == 2'b00 && dq_out == 2'b00 && wel == 1'b0, "R1 after reset",
          int'({dq_oe, dq_out, wel}), 0);

    // R10: preload the array
    for (int i = 0; i < 64; i++) begin
      otp_we = 1'b1; otp_waddr = 6'(i); otp_wdata = pat(i);
      @(negedge clk);
    end
    otp_we = 1'b0;

    // R3: Write Enable cut after 3 clocks
    select(); send_byte(8'h06, 3); deselect();
    check(wel == 1'b0, "R3 short wren", int'(wel), 0);
    // R3: Write Enable with an extra clock
    select(); send_byte(8'h06, 4); clk_grp(2'b00, so, soe); deselect();
    check(wel == 1'b0, "R3 long wren", int'(wel), 0);

    // R4: unknown opcode then 20 clocks
    select(); send_byte(8'h9F, 4);
    for (int i = 0; i < 20; i++) begin
      clk_grp(2'(i), so, soe);
      check(soe == 2'b00, "R4 unknown oe", int'(soe), 0);
    end
    deselect();
    check(wel == 1'b0, "R4 unknown wel", int'(wel), 0);

    // R2: proper Write Enable
    select(); send_byte(8'h06, 4); deselect();
    check(wel == 1'b1, "R2 wren sets", int'(wel), 1);

    // R5 R8: sweep every start byte with varying upper address bits
    for (int s = 0; s < 64; s++) rd_otp({18'(s * 1237 + 5), 6'(s)}, 2);

    // R8: long read across the wrap
    rd_otp({18'h2AAAA, 6'd60}, 68);

    // R9: abort mid-read then decode a fresh command
    select(); send_byte(8'h4B, 4);
    for (int i = 0; i < 12; i++) clk_grp(2'b00, so, soe);
    for (int i = 0; i < 10; i++) clk_grp(2'b00, so, soe);
    check(soe == 2'b11, "R9 driving before abort", int'(soe), 3);
    deselect();
    check(dq_oe == 2'b00, "R9 abort tristate", int'(dq_oe), 0);
    rd_otp(24'h000003, 1);

    // R10: overwrite one byte and read it back
    @(negedge clk); otp_we = 1'b1; otp_waddr = 6'd5; otp_wdata = 8'hA5;
    @(negedge clk); otp_we = 1'b0;
    select(); send_byte(8'h4B, 4);
    for (int i = 0; i < 12; i++) clk_grp(i == 11 ? 2'b01 : (i == 10 ? 2'b01 : 2'b00), so, soe);
    for (int i = 0; i < 8; i++) clk_grp(2'b00, so, soe);
    got = '0;
    for (int k = 0; k < 4; k++) begin clk_grp(2'b00, so, soe); got = {got[5:0], so}; end
    deselect();
    check(got == 8'hA5, "R10 preload overwrite", int'(got), 'hA5);

    // R11: wel still set after many commands
    check(wel == 1'b1, "R11 wel sticky", int'(wel), 1);
    rst = 1'b1; repeat (3) @(negedge clk); rst = 1'b0; repeat (3) @(negedge clk);
    check(wel == 1'b0, "R1 R11 reset clears wel", int'(wel), 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int c = 0; c < WATCHDOG; c++) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule